// File: doc/BRIEF.md
# Jump-Counter Control Unit

This block sequences a small accumulator processor. Its whole control state is a 4-bit counter that, on each clock, either holds, counts up by one, clears to zero or loads a jump target. Straight-line steps of a fetch or an execute sequence sit on consecutive counter values, so they advance by counting. The single multi-way branch, on the opcode, is a load from a four-entry target table. All other exits return to zero by clearing.

From the counter value, the synchronized memory Wait handshake, the two opcode bits and the accumulator sign bit, a decoder drives one strobe per register transfer. These are the PC clear and increment, the loads of MAR, MBR, IR, AC and PC, the memory request, the read/write direction and the ALU add. The processor reset and Wait each pass through a one-flop synchronizer before any control logic sees them.

Top module: `jc_ctrl_unit`

## Requirements
- R1: `rst` reaches the control logic one clock after it is sampled. While the synchronized reset is high, `pc_clr_o` is 1 and every other strobe is 0. The counter is 0 one edge later, so the first cycle after reset release shows the state-0 strobes.
- R2: In state 4 (decode), the counter loads a target chosen by `opcode_i`: 2'b00 goes to 5 (load), 2'b01 to 8 (store), 2'b10 to 10 (add) and 2'b11 to 13 (branch).
- R3: States 0, 3, 5, 8 and 10 advance by one on every clock. State 0 drives `mar_from_pc_o` and `pc_inc_o`. State 3 drives `ir_from_mbr_o`.
- R4: State 1 (first fetch wait) drives `mem_req_o` and `mem_read_o`. It holds until the synchronized Wait is 1, then counts.
- R5: The read-wait states 2, 6 and 11 drive `mem_req_o` and `mem_read_o`, and hold while the synchronized Wait is 1. `mbr_from_mem_o` is 1 only in the cycle in which Wait is seen low, and the counter leaves the state on the next edge.
- R6: Decode drives `mar_from_ir_o` for opcodes 2'b00, 2'b01 and 2'b10, and not for 2'b11. It drives `mbr_from_ac_o` for opcode 2'b01 only.
- R7: State 7 drives `ac_from_mbr_o`, and the counter then clears to 0.
- R8: States 8 and 9 drive `mem_req_o` and `mbr_to_mem_o` with `mem_read_o` at 0. State 9 holds while the synchronized Wait is 1 and clears to 0 once it is 0.
- R9: State 12 drives `ac_from_sum_o`, and the counter then clears to 0.
- R10: State 13 drives `pc_from_ir_o` only when `ac_sign_i` is 1, and clears to 0 either way.
- R11: A change on `mem_wait_i` affects the strobes and the counter one clock later than a direct connection would.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Processor reset, active high, synchronized inside |
| mem_wait_i | input | 1 | Memory Wait handshake, synchronized inside |
| opcode_i | input | 2 | Opcode bits of the instruction register |
| ac_sign_i | input | 1 | Accumulator sign bit |
| pc_clr_o | output | 1 | Clear PC to zero |
| pc_inc_o | output | 1 | Increment PC |
| mar_from_pc_o | output | 1 | Load MAR from PC |
| mar_from_ir_o | output | 1 | Load MAR from the IR address field |
| mbr_from_mem_o | output | 1 | Capture the memory data bus into MBR |
| mbr_from_ac_o | output | 1 | Load MBR from AC |
| mbr_to_mem_o | output | 1 | Drive MBR onto the memory data bus |
| ir_from_mbr_o | output | 1 | Load IR from MBR |
| ac_from_mbr_o | output | 1 | Load AC from MBR |
| ac_from_sum_o | output | 1 | Load AC with the ALU sum of AC and MBR |
| pc_from_ir_o | output | 1 | Load PC from the IR address field |
| mem_req_o | output | 1 | Memory request |
| mem_read_o | output | 1 | Access direction, 1 read, 0 write |

## Verification
Every strobe is decoded from the counter in the same cycle, so a wrong counter value shows at the ports at once as a strobe pattern that belongs to another state. A wrong hold or advance shows either as a pattern that repeats one cycle too many or as a missing step. A bad jump target shows in the cycle after decode, when the load, store, add or branch pattern should appear. Handshake faults are seen by moving Wait one cycle at a time and checking that capture and exit fall exactly one cycle after the synchronizer delay.

// File: rtl/jc_pkg.sv
package jc_pkg;

    localparam int ST_W = 4;
    typedef logic [ST_W-1:0] st_t;

    // Counter values; consecutive numbering lets straight-line steps count.
    localparam st_t S_FETCH  = 4'd0;
    localparam st_t S_FREQ   = 4'd1;
    localparam st_t S_FWAIT  = 4'd2;
    localparam st_t S_IRLD   = 4'd3;
    localparam st_t S_DECODE = 4'd4;
    localparam st_t S_LDREQ  = 4'd5;
    localparam st_t S_LDWAIT = 4'd6;
    localparam st_t S_LDWB   = 4'd7;
    localparam st_t S_STREQ  = 4'd8;
    localparam st_t S_STWAIT = 4'd9;
    localparam st_t S_ADREQ  = 4'd10;
    localparam st_t S_ADWAIT = 4'd11;
    localparam st_t S_ADWB   = 4'd12;
    localparam st_t S_BRANCH = 4'd13;

    typedef enum logic [1:0] {
        OP_LOAD   = 2'b00,
        OP_STORE  = 2'b01,
        OP_ADD    = 2'b10,
        OP_BRANCH = 2'b11
    } op_e;

    typedef struct packed {
        logic pc_clr;
        logic pc_inc;
        logic mar_from_pc;
        logic mar_from_ir;
        logic mbr_from_mem;
        logic mbr_from_ac;
        logic mbr_to_mem;
        logic ir_from_mbr;
        logic ac_from_mbr;
        logic ac_from_sum;
        logic pc_from_ir;
        logic mem_req;
        logic mem_read;
    } strobe_t;

    // Four-entry jump table indexed by opcode.
    function automatic st_t jump_target(op_e op);
        case (op)
            OP_LOAD:   return S_LDREQ;
            OP_STORE:  return S_STREQ;
            OP_ADD:    return S_ADREQ;
            default:   return S_BRANCH;
        endcase
    endfunction

endpackage

// File: rtl/jc_sync.sv
module jc_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 1
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        logic [WIDTH-1:0] r;
        if (i == 0) begin : g_first
            always_ff @(posedge clk) r <= d;
        end else begin : g_next
            always_ff @(posedge clk) r <= g_stage[i-1].r;
        end
    end

    assign q = g_stage[STAGES-1].r;
endmodule

// File: rtl/jc_next_ctl.sv
module jc_next_ctl
    import jc_pkg::*;
(
    input  st_t        state,
    input  logic       rst_s,
    input  logic       wait_s,
    input  logic [1:0] opcode,
    output logic       cnt_en,
    output logic       clr_en,
    output logic       ld_en,
    output st_t        target
);
    always_comb begin
        cnt_en = 1'b0;
        clr_en = 1'b0;
        ld_en  = 1'b0;
        target = jump_target(op_e'(opcode));
        if (rst_s) begin
            clr_en = 1'b1;
        end else begin
            case (state)
                S_FETCH, S_IRLD, S_LDREQ, S_STREQ, S_ADREQ: cnt_en = 1'b1;
                S_FREQ:                                     cnt_en = wait_s;
                S_FWAIT, S_LDWAIT, S_ADWAIT:                cnt_en = !wait_s;
                S_DECODE:                                   ld_en  = 1'b1;
                S_STWAIT:                                   clr_en = !wait_s;
                default:                                    clr_en = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/jc_counter.sv
module jc_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         clr,
    input  logic         ld,
    input  logic         cnt,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    // Priority: clear, then load, then count; otherwise hold.
    always_ff @(posedge clk) begin
        if (clr)      q <= '0;
        else if (ld)  q <= din;
        else if (cnt) q <= q + 1'b1;
    end
endmodule

// File: rtl/jc_strobe_dec.sv
module jc_strobe_dec
    import jc_pkg::*;
(
    input  st_t        state,
    input  logic       rst_s,
    input  logic       wait_s,
    input  logic [1:0] opcode,
    input  logic       ac_sign,
    output strobe_t    strb
);
    op_e op;
    assign op = op_e'(opcode);

    always_comb begin
        strb = '0;
        if (rst_s) begin
            strb.pc_clr = 1'b1;
        end else begin
            case (state)
                S_FETCH: begin
                    strb.pc_inc      = 1'b1;
                    strb.mar_from_pc = 1'b1;
                end
                S_FREQ, S_LDREQ, S_ADREQ: begin
                    strb.mem_req  = 1'b1;
                    strb.mem_read = 1'b1;
                end
                S_FWAIT, S_LDWAIT, S_ADWAIT: begin
                    strb.mem_req      = 1'b1;
                    strb.mem_read     = 1'b1;
                    strb.mbr_from_mem = !wait_s;
                end
                S_IRLD:   strb.ir_from_mbr = 1'b1;
                S_DECODE: begin
                    strb.mar_from_ir = (op != OP_BRANCH);
                    strb.mbr_from_ac = (op == OP_STORE);
                end
                S_LDWB:   strb.ac_from_mbr = 1'b1;
                S_STREQ, S_STWAIT: begin
                    strb.mem_req    = 1'b1;
                    strb.mbr_to_mem = 1'b1;
                end
                S_ADWB:   strb.ac_from_sum = 1'b1;
                S_BRANCH: strb.pc_from_ir  = ac_sign;
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/jc_ctrl_unit.sv
module jc_ctrl_unit
    import jc_pkg::*;
#(
    parameter int SYNC_STAGES = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       mem_wait_i,
    input  logic [1:0] opcode_i,
    input  logic       ac_sign_i,
    output logic       pc_clr_o,
    output logic       pc_inc_o,
    output logic       mar_from_pc_o,
    output logic       mar_from_ir_o,
    output logic       mbr_from_mem_o,
    output logic       mbr_from_ac_o,
    output logic       mbr_to_mem_o,
    output logic       ir_from_mbr_o,
    output logic       ac_from_mbr_o,
    output logic       ac_from_sum_o,
    output logic       pc_from_ir_o,
    output logic       mem_req_o,
    output logic       mem_read_o
);
    logic [1:0] sync_q;
    logic       rst_s;
    logic       wait_s;
    st_t        state_q;
    st_t        target;
    logic       cnt_en;
    logic       clr_en;
    logic       ld_en;
    strobe_t    strb;

    jc_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .d   ({rst, mem_wait_i}),
        .q   (sync_q)
    );
    assign rst_s  = sync_q[1];
    assign wait_s = sync_q[0];

    jc_next_ctl u_next (
        .state  (state_q),
        .rst_s  (rst_s),
        .wait_s (wait_s),
        .opcode (opcode_i),
        .cnt_en (cnt_en),
        .clr_en (clr_en),
        .ld_en  (ld_en),
        .target (target)
    );

    jc_counter #(.W(ST_W)) u_cnt (
        .clk (clk),
        .clr (clr_en),
        .ld  (ld_en),
        .cnt (cnt_en),
        .din (target),
        .q   (state_q)
    );

    jc_strobe_dec u_dec (
        .state   (state_q),
        .rst_s   (rst_s),
        .wait_s  (wait_s),
        .opcode  (opcode_i),
        .ac_sign (ac_sign_i),
        .strb    (strb)
    );

    assign pc_clr_o       = strb.pc_clr;
    assign pc_inc_o       = strb.pc_inc;
    assign mar_from_pc_o  = strb.mar_from_pc;
    assign mar_from_ir_o  = strb.mar_from_ir;
    assign mbr_from_mem_o = strb.mbr_from_mem;
    assign mbr_from_ac_o  = strb.mbr_from_ac;
    assign mbr_to_mem_o   = strb.mbr_to_mem;
    assign ir_from_mbr_o  = strb.ir_from_mbr;
    assign ac_from_mbr_o  = strb.ac_from_mbr;
    assign ac_from_sum_o  = strb.ac_from_sum;
    assign pc_from_ir_o   = strb.pc_from_ir;
    assign mem_req_o      = strb.mem_req;
    assign mem_read_o     = strb.mem_read;
endmodule

// File: rtl/jc_ctrl_checker.sv
module jc_ctrl_checker
    import jc_pkg::*;
(
    input logic       clk,
    input logic       rst_s,
    input logic       wait_s,
    input logic [1:0] opcode_i,
    input st_t        state_q,
    input logic       pc_clr_o,
    input logic       pc_inc_o,
    input logic       mem_req_o,
    input logic       mem_read_o,
    input logic       ir_from_mbr_o,
    input logic       mbr_from_mem_o,
    input logic       mbr_to_mem_o,
    input logic       ac_from_mbr_o,
    input logic       ac_from_sum_o,
    input logic       pc_from_ir_o
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst_s |=> (state_q == S_FETCH)); // R1

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst_s |-> (pc_clr_o && !pc_inc_o && !mem_req_o && !ir_from_mbr_o)); // R1

    AST_JUMP_MAP: assert property (@(posedge clk) disable iff (rst_s)
        (state_q == S_DECODE) |=> (state_q == jump_target(op_e'($past(opcode_i))))); // R2

    AST_FETCH_STEP: assert property (@(posedge clk) disable iff (rst_s)
        (state_q == S_FETCH) |=> (state_q == S_FREQ)); // R3

    AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (rst_s)
        (state_q == S_FREQ && !wait_s) |=> (state_q == S_FREQ)); // R4

    AST_CAPTURE_EXIT: assert property (@(posedge clk) disable iff (rst_s)
        mbr_from_mem_o |=> (state_q != $past(state_q))); // R5

    AST_LOAD_RETURN: assert property (@(posedge clk) disable iff (rst_s)
        ac_from_mbr_o |=> (state_q == S_FETCH)); // R7

    AST_STORE_WRITE: assert property (@(posedge clk) disable iff (rst_s)
        mbr_to_mem_o |-> (mem_req_o && !mem_read_o)); // R8

    AST_ADD_RETURN: assert property (@(posedge clk) disable iff (rst_s)
        ac_from_sum_o |=> (state_q == S_FETCH)); // R9

    AST_BRANCH_RETURN: assert property (@(posedge clk) disable iff (rst_s)
        pc_from_ir_o |=> (state_q == S_FETCH)); // R10
endmodule

bind jc_ctrl_unit jc_ctrl_checker u_chk (
    .clk            (clk),
    .rst_s          (rst_s),
    .wait_s         (wait_s),
    .opcode_i       (opcode_i),
    .state_q        (state_q),
    .pc_clr_o       (pc_clr_o),
    .pc_inc_o       (pc_inc_o),
    .mem_req_o      (mem_req_o),
    .mem_read_o     (mem_read_o),
    .ir_from_mbr_o  (ir_from_mbr_o),
    .mbr_from_mem_o (mbr_from_mem_o),
    .mbr_to_mem_o   (mbr_to_mem_o),
    .ac_from_mbr_o  (ac_from_mbr_o),
    .ac_from_sum_o  (ac_from_sum_o),
    .pc_from_ir_o   (pc_from_ir_o)
);

// File: tb/sim_jc_ctrl_unit.sv
module sim_jc_ctrl_unit;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CLK_PER = 10;

    // Strobe vector order (bit 12 down to 0):
    // pc_clr pc_inc mar_from_pc mar_from_ir mbr_from_mem mbr_from_ac
    // mbr_to_mem ir_from_mbr ac_from_mbr ac_from_sum pc_from_ir mem_req mem_read
    localparam logic [12:0] E_RST   = 13'h1000;
    localparam logic [12:0] E_S0    = 13'h0C00;
    localparam logic [12:0] E_RD    = 13'h0003;
    localparam logic [12:0] E_CAPT  = 13'h0103;
    localparam logic [12:0] E_IR    = 13'h0020;
    localparam logic [12:0] E_DADDR = 13'h0200;
    localparam logic [12:0] E_DST   = 13'h0280;
    localparam logic [12:0] E_WR    = 13'h0042;
    localparam logic [12:0] E_ACMBR = 13'h0010;
    localparam logic [12:0] E_SUM   = 13'h0008;
    localparam logic [12:0] E_BR    = 13'h0004;
    localparam logic [12:0] E_NONE  = 13'h0000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mem_wait_i = 1'b0;
    logic [1:0] opcode_i = 2'b00;
    logic       ac_sign_i = 1'b0;
    logic pc_clr_o, pc_inc_o, mar_from_pc_o, mar_from_ir_o, mbr_from_mem_o;
    logic mbr_from_ac_o, mbr_to_mem_o, ir_from_mbr_o, ac_from_mbr_o;
    logic ac_from_sum_o, pc_from_ir_o, mem_req_o, mem_read_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PER/2) clk = ~clk;

    jc_ctrl_unit u0 (
        .clk(clk), .rst(rst), .mem_wait_i(mem_wait_i), .opcode_i(opcode_i),
        .ac_sign_i(ac_sign_i), .pc_clr_o(pc_clr_o), .pc_inc_o(pc_inc_o),
        .mar_from_pc_o(mar_from_pc_o), .mar_from_ir_o(mar_from_ir_o),
        .mbr_from_mem_o(mbr_from_mem_o), .mbr_from_ac_o(mbr_from_ac_o),
        .mbr_to_mem_o(mbr_to_mem_o), .ir_from_mbr_o(ir_from_mbr_o),
        .ac_from_mbr_o(ac_from_mbr_o), .ac_from_sum_o(ac_from_sum_o),
        .pc_from_ir_o(pc_from_ir_o), .mem_req_o(mem_req_o), .mem_read_o(mem_read_o)
    );

    logic [12:0] obs;
    assign obs = {pc_clr_o, pc_inc_o, mar_from_pc_o, mar_from_ir_o, mbr_from_mem_o,
                  mbr_from_ac_o, mbr_to_mem_o, ir_from_mbr_o, ac_from_mbr_o,
                  ac_from_sum_o, pc_from_ir_o, mem_req_o, mem_read_o};

    task automatic tick();
        @(posedge clk);
        #(CLK_PER/4);
    endtask

    task automatic chk(input logic [12:0] exp, input string tag);
        checks++;
        if (obs !== exp) begin
            errors++;
            $display("FAIL %s: strobes %h expected %h", tag, obs, exp);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        tick(); tick();
        chk(E_RST, "R1 strobes while reset held");
        rst = 1'b0;
        chk(E_RST, "R1 release not seen before sync edge");
        tick();
        chk(E_S0, "R1 state 0 after release");
    endtask

    // Starts with state 0 visible and Wait low; ends with decode visible.
    task automatic t_fetch(input logic [1:0] op);
        opcode_i = op;
        chk(E_S0, "R3 state 0 strobes");
        tick(); chk(E_RD, "R4 first fetch wait");
        tick(); chk(E_RD, "R4 hold while Wait low");
        mem_wait_i = 1'b1;
        tick(); chk(E_RD, "R11 Wait rise not yet seen");
        tick(); chk(E_RD, "R5 read wait, no capture while Wait high");
        mem_wait_i = 1'b0;
        tick(); chk(E_CAPT, "R5 capture when Wait low");
        tick(); chk(E_IR, "R3 IR load step");
        tick();
        case (op)
            2'b00, 2'b10: chk(E_DADDR, "R6 decode address load");
            2'b01:        chk(E_DST, "R6 decode store");
            default:      chk(E_NONE, "R6 decode branch");
        endcase
    endtask

    task automatic t_load();
        tick(); chk(E_RD, "R2 R3 load request step");
        mem_wait_i = 1'b1;
        tick(); chk(E_RD, "R5 load wait high");
        tick(); chk(E_RD, "R5 load wait hold");
        mem_wait_i = 1'b0;
        tick(); chk(E_CAPT, "R5 load capture");
        tick(); chk(E_ACMBR, "R7 MBR to AC");
        tick(); chk(E_S0, "R7 return to 0");
    endtask

    task automatic t_store();
        mem_wait_i = 1'b1;
        tick(); chk(E_WR, "R2 R8 store request");
        tick(); chk(E_WR, "R8 store wait");
        tick(); chk(E_WR, "R8 store hold while Wait high");
        mem_wait_i = 1'b0;
        tick(); chk(E_WR, "R11 store Wait fall not yet seen");
        tick(); chk(E_S0, "R8 store return to 0");
    endtask

    task automatic t_add();
        tick(); chk(E_RD, "R2 R3 add request step");
        tick(); chk(E_CAPT, "R5 add capture");
        tick(); chk(E_SUM, "R9 sum to AC");
        tick(); chk(E_S0, "R9 return to 0");
    endtask

    task automatic t_branch(input logic neg);
        tick();
        chk(neg ? E_BR : E_NONE, neg ? "R2 R10 taken branch" : "R2 R10 untaken branch");
        tick(); chk(E_S0, "R10 return to 0");
    endtask

    task automatic t_reset_mid();
        tick(); chk(E_RD, "R4 entry before reset");
        rst = 1'b1;
        tick(); chk(E_RST, "R1 reset mid-fetch");
        rst = 1'b0;
        tick(); chk(E_S0, "R1 restart at 0");
    endtask

    initial begin
        t_reset();
        t_fetch(2'b00); t_load();
        t_fetch(2'b01); t_store();
        t_fetch(2'b10); t_add();
        ac_sign_i = 1'b1;
        t_fetch(2'b11); t_branch(1'b1);
        ac_sign_i = 1'b0;
        t_fetch(2'b11); t_branch(1'b0);
        t_reset_mid();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PER * 20000);
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule